// File: doc/BRIEF.md
# Banked Program Counter with Return Stack

This unit produces the 12-bit fetch address for a small controller whose 4K program space is split into two 2K halves. The low eleven bits move by increment, by jump or call target, or by return. The top bit is the bank bit. It changes only when a branch is taken. A separate pending-bank flip-flop holds the bank that the next jump or call will enter. Two bank-select strobes write this flip-flop, and neither of them moves the address.

Calls and interrupts push the full 12-bit address onto a small circular return stack, so subroutines can cross the bank boundary and still come back correctly. An interrupt sends execution to one of two fixed vectors in bank 0. While the handler runs, every branch and plain return lands in bank 0. The return-and-restore-status operation ends the handler and restores the saved address in full. Instruction decode and program memory belong to the surrounding logic. That logic raises at most the strobes of one instruction per cycle. A fixed priority settles any overlap.

Top module: `pcBankTop`

## Requirements
- R1: While reset (rstN low) is asserted, pcOut is 0x000. Reset also clears the pending-bank flip-flop and leaves the unit outside interrupt service.
- R2: An increment adds one to pcOut[10:0], wrapping modulo 2048. It leaves pcOut[11] unchanged.
- R3: Outside interrupt service, a jump loads pcOut[10:0] from jumpTarget and pcOut[11] from the pending-bank flip-flop. The flip-flop value used is the one held before that clock edge.
- R4: selBank1 sets the pending-bank flip-flop and selBank0 clears it. When both are high in the same cycle, selBank1 wins. A cycle with only a bank select leaves pcOut unchanged.
- R5: Sequential execution never leaves the current bank: 0x7FF increments to 0x000 and 0xFFF increments to 0x800.
- R6: A call pushes the next sequential address (formed as in R2) and branches as in R3. A return pops all 12 bits into pcOut and does not alter the pending-bank flip-flop.
- R7: An accepted interrupt pushes the current pcOut, enters interrupt service and loads 0x003 when intVecSel is 0 or 0x007 when it is 1. The return-and-restore-status operation pops all 12 bits and leaves interrupt service.
- R8: During interrupt service, jump, call and plain return load pcOut[11] as 0. A bank select in that time changes only the flip-flop, and the new value takes effect on the first jump after service ends.
- R9: An interrupt request raised during interrupt service is ignored. With no other operation in that cycle, pcOut holds.
- R10: The return stack holds 8 entries and is circular. A ninth push overwrites the oldest entry, and pops return the entries in last-in first-out order around the ring.
- R11: When several operations coincide, one acts, in this order: accepted interrupt, return-and-restore-status, return, call, jump, increment. Bank selects act in parallel with any of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| incEn | input | 1 | Advance to next sequential address |
| jumpEn | input | 1 | Jump to jumpTarget |
| callEn | input | 1 | Call jumpTarget, pushing return address |
| retEn | input | 1 | Plain return from subroutine |
| retrEn | input | 1 | Return that also ends interrupt service |
| jumpTarget | input | 11 | Low address bits for jump or call |
| selBank0 | input | 1 | Clear pending-bank flip-flop |
| selBank1 | input | 1 | Set pending-bank flip-flop |
| intReq | input | 1 | Interrupt vector request |
| intVecSel | input | 1 | Vector choice: 0 gives 0x003, 1 gives 0x007 |
| pcOut | output | 12 | Current program address |

## Verification
The bench goes after the deferred bank bit. A design that copied the flip-flop into bit 11 at the moment of selection would jump early, and one that let the increment carry into bit 11 would leave the bank at 0x7FF or 0xFFF. Inside an interrupt handler, the bench selects bank 1 and then jumps, calls and returns. A design that failed to force bit 11 low would land in the upper half, and one that lost the pending selection would return to the wrong bank after service ends. Nine nested calls check the circular overwrite. Overlapping strobes and a nested interrupt request check the priority order and the rule that a second request is ignored. A reset in mid-run shows whether the bank flip-flop and the service state are really cleared.

// File: rtl/pcBankPkg.sv
package pcBankPkg;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_INC,
    OP_JUMP,
    OP_CALL,
    OP_POP,
    OP_VEC
  } pcOp_e;

  // Strobes from control to datapath, one operation per cycle
  typedef struct packed {
    pcOp_e op;
    logic  push;     // write a stack entry this cycle
    logic  pushCur;  // 1: push pc as is, 0: push next sequential
    logic  hiBit;    // bank bit for a jump or call
    logic  maskHi;   // force bank bit of a popped address to 0
    logic  vecSel;   // which interrupt vector
  } pcStrobe_t;

endpackage

// File: rtl/pcBankCtrl.sv
module pcBankCtrl
  import pcBankPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      incEn,
  input  logic      jumpEn,
  input  logic      callEn,
  input  logic      retEn,
  input  logic      retrEn,
  input  logic      selBank0,
  input  logic      selBank1,
  input  logic      intReq,
  input  logic      intVecSel,
  output pcStrobe_t strb
);

  logic bankFf;
  logic inIsr;
  logic intTake;

  assign intTake = intReq & ~inIsr;

  // pending bank: set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankFf <= 1'b0;
    end else if (selBank1) begin
      bankFf <= 1'b1;
    end else if (selBank0) begin
      bankFf <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inIsr <= 1'b0;
    end else if (intTake) begin
      inIsr <= 1'b1;
    end else if (retrEn) begin
      inIsr <= 1'b0;
    end
  end

  always_comb begin
    strb         = '0;
    strb.op      = OP_HOLD;
    strb.hiBit   = bankFf & ~inIsr;
    strb.vecSel  = intVecSel;
    if (intTake) begin
      strb.op      = OP_VEC;
      strb.push    = 1'b1;
      strb.pushCur = 1'b1;
    end else if (retrEn) begin
      strb.op     = OP_POP;
      strb.maskHi = 1'b0;
    end else if (retEn) begin
      strb.op     = OP_POP;
      strb.maskHi = inIsr;
    end else if (callEn) begin
      strb.op   = OP_CALL;
      strb.push = 1'b1;
    end else if (jumpEn) begin
      strb.op = OP_JUMP;
    end else if (incEn) begin
      strb.op = OP_INC;
    end
  end

endmodule

// File: rtl/pcBankPath.sv
module pcBankPath
  import pcBankPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 8,
  parameter int VEC_A       = 3,
  parameter int VEC_B       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcStrobe_t         strb,
  input  logic [ADDR_W-2:0] jumpTarget,
  output logic [ADDR_W-1:0] pcOut
);

  localparam int LOW_W = ADDR_W - 1;
  localparam int SP_W  = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  logic [ADDR_W-1:0] pcReg;
  logic [ADDR_W-1:0] seqAddr;
  logic [ADDR_W-1:0] pushVal;
  logic [ADDR_W-1:0] popVal;
  logic [ADDR_W-1:0] pcNext;
  logic [SP_W-1:0]   sp;
  logic [SP_W-1:0]   popIdx;
  logic [ADDR_W-1:0] stackMem [STACK_DEPTH];

  assign seqAddr = {pcReg[ADDR_W-1], pcReg[LOW_W-1:0] + 1'b1};
  assign pushVal = strb.pushCur ? pcReg : seqAddr;
  assign popIdx  = sp - 1'b1;
  assign popVal  = stackMem[popIdx];

  // one register per stack slot
  for (genvar g = 0; g < STACK_DEPTH; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stackMem[g] <= '0;
      end else if (strb.push && (sp == SP_W'(g))) begin
        stackMem[g] <= pushVal;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sp <= '0;
    end else if (strb.push) begin
      sp <= sp + 1'b1;
    end else if (strb.op == OP_POP) begin
      sp <= popIdx;
    end
  end

  always_comb begin
    case (strb.op)
      OP_INC:           pcNext = seqAddr;
      OP_JUMP, OP_CALL: pcNext = {strb.hiBit, jumpTarget};
      OP_POP:           pcNext = {popVal[ADDR_W-1] & ~strb.maskHi,
                                  popVal[LOW_W-1:0]};
      OP_VEC:           pcNext = strb.vecSel ? ADDR_W'(VEC_B) : ADDR_W'(VEC_A);
      default:          pcNext = pcReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= '0;
    end else begin
      pcReg <= pcNext;
    end
  end

  assign pcOut = pcReg;

endmodule

// File: rtl/pcBankTop.sv
module pcBankTop
  import pcBankPkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int STACK_DEPTH = 8,
  parameter int VEC_A       = 3,
  parameter int VEC_B       = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              incEn,
  input  logic              jumpEn,
  input  logic              callEn,
  input  logic              retEn,
  input  logic              retrEn,
  input  logic [ADDR_W-2:0] jumpTarget,
  input  logic              selBank0,
  input  logic              selBank1,
  input  logic              intReq,
  input  logic              intVecSel,
  output logic [ADDR_W-1:0] pcOut
);

  pcStrobe_t strb;

  pcBankCtrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .incEn     (incEn),
    .jumpEn    (jumpEn),
    .callEn    (callEn),
    .retEn     (retEn),
    .retrEn    (retrEn),
    .selBank0  (selBank0),
    .selBank1  (selBank1),
    .intReq    (intReq),
    .intVecSel (intVecSel),
    .strb      (strb)
  );

  pcBankPath #(
    .ADDR_W      (ADDR_W),
    .STACK_DEPTH (STACK_DEPTH),
    .VEC_A       (VEC_A),
    .VEC_B       (VEC_B)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .jumpTarget (jumpTarget),
    .pcOut      (pcOut)
  );

endmodule

// File: rtl/pcBankChk.sv
module pcBankChk #(
  parameter int ADDR_W = 12,
  parameter int VEC_A  = 3,
  parameter int VEC_B  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              incEn,
  input logic              jumpEn,
  input logic              callEn,
  input logic              retEn,
  input logic              retrEn,
  input logic [ADDR_W-2:0] jumpTarget,
  input logic              selBank0,
  input logic              selBank1,
  input logic              intReq,
  input logic              intVecSel,
  input logic [ADDR_W-1:0] pcOut
);

  localparam int LOW_W = ADDR_W - 1;

  logic isrSh;
  logic intOk;
  logic noBranch;

  assign intOk    = intReq & ~isrSh;
  assign noBranch = ~jumpEn & ~callEn & ~retEn & ~retrEn & ~intOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isrSh <= 1'b0;
    end else if (intOk) begin
      isrSh <= 1'b1;
    end else if (retrEn) begin
      isrSh <= 1'b0;
    end
  end

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (incEn && noBranch) |=>
      (pcOut == {$past(pcOut[ADDR_W-1]), $past(pcOut[LOW_W-1:0]) + 1'b1}));

  // R3
  jump_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (jumpEn && !callEn && !retEn && !retrEn && !intOk) |=>
      (pcOut[LOW_W-1:0] == $past(jumpTarget)));

  // R4
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((selBank0 || selBank1) && !incEn && noBranch) |=> $stable(pcOut));

  // R7
  vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    intOk |=> (pcOut == ($past(intVecSel) ? ADDR_W'(VEC_B) : ADDR_W'(VEC_A))));

  // R8
  isr_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isrSh && (jumpEn || callEn || retEn) && !retrEn) |=> !pcOut[ADDR_W-1]);

endmodule

bind pcBankTop pcBankChk #(
  .ADDR_W (ADDR_W),
  .VEC_A  (VEC_A),
  .VEC_B  (VEC_B)
) uChk (.*);

// File: tb/sim_pcBankTop.sv
module sim_pcBankTop;

  localparam int F_INC  = 1;
  localparam int F_JMP  = 2;
  localparam int F_CALL = 4;
  localparam int F_RET  = 8;
  localparam int F_RETR = 16;
  localparam int F_S0   = 32;
  localparam int F_S1   = 64;
  localparam int F_INT  = 128;
  localparam int F_VSEL = 256;

  typedef struct {
    logic [11:0] val;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        incEn = 0, jumpEn = 0, callEn = 0, retEn = 0, retrEn = 0;
  logic        selBank0 = 0, selBank1 = 0, intReq = 0, intVecSel = 0;
  logic [10:0] jumpTarget = '0;
  logic [11:0] pcOut;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  expItem_t    expQ[$];
  logic [11:0] mPc;
  logic        mBank;
  logic        mIsr;
  logic [11:0] mStack[8];
  int          mSp;

  always #5 clk = ~clk;

  pcBankTop u0 (
    .clk(clk), .rstN(rstN), .incEn(incEn), .jumpEn(jumpEn), .callEn(callEn),
    .retEn(retEn), .retrEn(retrEn), .jumpTarget(jumpTarget),
    .selBank0(selBank0), .selBank1(selBank1), .intReq(intReq),
    .intVecSel(intVecSel), .pcOut(pcOut)
  );

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: pcOut=%03h expected=%03h", tag, act, exp);
    end
  endtask

  // monitor: compare one result per driven cycle after the edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      check(pcOut, e.val, e.tag);
    end
  end

  function automatic logic [11:0] seqOf(input logic [11:0] p);
    return {p[11], p[10:0] + 11'd1};
  endfunction

  // driver: apply one cycle of strobes, update the model, queue expectation
  task automatic step(input int f, input logic [10:0] tgt, input string tag);
    logic take;
    @(negedge clk);
    incEn = (f & F_INC) != 0;   jumpEn = (f & F_JMP) != 0;
    callEn = (f & F_CALL) != 0; retEn = (f & F_RET) != 0;
    retrEn = (f & F_RETR) != 0; selBank0 = (f & F_S0) != 0;
    selBank1 = (f & F_S1) != 0; intReq = (f & F_INT) != 0;
    intVecSel = (f & F_VSEL) != 0; jumpTarget = tgt;
    take = intReq && !mIsr;
    if (take) begin
      mStack[mSp] = mPc; mSp = (mSp + 1) % 8;
      mPc = intVecSel ? 12'h007 : 12'h003; mIsr = 1;
    end else if (retrEn) begin
      mSp = (mSp + 7) % 8; mPc = mStack[mSp]; mIsr = 0;
    end else if (retEn) begin
      mSp = (mSp + 7) % 8; mPc = mStack[mSp];
      if (mIsr) mPc[11] = 1'b0;
    end else if (callEn) begin
      mStack[mSp] = seqOf(mPc); mSp = (mSp + 1) % 8;
      mPc = {mBank & ~mIsr, tgt};
    end else if (jumpEn) begin
      mPc = {mBank & ~mIsr, tgt};
    end else if (incEn) begin
      mPc = seqOf(mPc);
    end
    if (selBank1) mBank = 1;
    else if (selBank0) mBank = 0;
    expQ.push_back('{mPc, tag});
  endtask

  task automatic doReset(input string tag);
    @(negedge clk);
    {incEn, jumpEn, callEn, retEn, retrEn, selBank0, selBank1, intReq, intVecSel} = '0;
    rstN = 0;
    mPc = 0; mBank = 0; mIsr = 0; mSp = 0;
    for (int i = 0; i < 8; i++) mStack[i] = 0;
    @(negedge clk);
    check(pcOut, 12'h000, tag);
    rstN = 1;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    doReset("R1 reset pc");
    step(F_INC, 0, "R2 inc 1");
    step(F_INC, 0, "R2 inc 2");
    step(0, 0, "R2 idle hold");
    step(F_JMP, 11'h123, "R3 jump bank0");
    step(F_S1, 0, "R4 select no move");
    step(F_INC, 0, "R4 bank deferred on inc");
    step(F_JMP, 11'h7FE, "R3 jump into bank1");
    step(F_INC, 0, "R5 to FFF");
    step(F_INC, 0, "R5 wrap to 800");
    step(F_JMP, 11'h7FF, "R3 jump 7FF bank1");
    step(F_S0, 0, "R4 clear no move");
    step(F_JMP, 11'h7FF, "R3 jump 7FF bank0");
    step(F_INC, 0, "R5 wrap to 000");
    step(F_S1, 0, "R4 set");
    step(F_CALL, 11'h010, "R6 call cross bank");
    step(F_S0, 0, "R4 clear");
    step(F_RET, 0, "R6 return full 12 bits");
    step(F_JMP, 11'h020, "R6 bank ff kept by return");
    step(F_INT | F_VSEL, 0, "R7 vector 7");
    step(F_S1, 0, "R8 select in isr");
    step(F_JMP, 11'h100, "R8 jump in isr bank0");
    step(F_CALL, 11'h050, "R8 call in isr bank0");
    step(F_RET, 0, "R8 ret in isr bank0");
    step(F_INT, 0, "R9 nested request ignored");
    step(F_RETR, 0, "R7 retr restores");
    step(F_JMP, 11'h033, "R8 pending bank after isr");
    step(F_INT, 0, "R7 vector 3");
    step(F_RETR | F_INC, 0, "R11 retr over inc");
    for (int i = 0; i < 9; i++) step(F_CALL, 11'(16 * i + 1), "R10 nested call");
    for (int i = 0; i < 9; i++) step(F_RET, 0, "R10 ring return");
    step(F_JMP | F_INC, 11'h0AA, "R11 jump over inc");
    step(F_CALL | F_JMP, 11'h0BB, "R11 call over jump");
    step(F_RET | F_CALL, 11'h0CC, "R11 ret over call");
    step(F_S0 | F_S1, 0, "R4 both selects");
    step(F_JMP, 11'h044, "R4 set wins");
    step(F_INT | F_RETR, 0, "R11 int over retr");
    step(F_S1, 0, "R1 set before reset");
    @(posedge clk); #2;
    doReset("R1 reset mid isr");
    step(F_JMP, 11'h055, "R1 bank cleared by reset");
    step(F_JMP, 11'h066, "R1 isr cleared by reset");
    step(F_INT, 0, "R1 int accepted after reset");
    @(posedge clk); #2;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule